// File: doc/BRIEF.md
# Debug Port Control and Status Register Unit

This unit holds the control and status word of a debug port, together with a separate write-only abort word. Its state comes in three kinds. Sticky error flags are set by one-cycle events from the access-port engine. A set of plain control fields goes out to that engine: byte-lane mask, transfer mode and overrun-detect enable. A 12-bit down-counter sets how many incremental-address transfers remain in an automatic sequence. The unit also drives the debug-clock power-up request and shows the matching acknowledge input in the word.

Software reaches the unit through a simple register port with a write strobe and a combinational read. The control and status word decodes at byte offset 0x04, and only while the externally held bank select value is zero. The abort word decodes at offset 0x00 in every bank. Writing the abort word clears chosen sticky flags and can cancel a stalled access-port transfer. It cancels by sending out a single-cycle abort strobe.

Top module: `dbgp_csr`

## Requirements
- R1: After a synchronous active-low reset the word reads 0x0000_0000 (with the acknowledge input low), `abort_pulse` and `pwr_req` are 0 and `seq_count` is 0.
- R2: The word is read and written only when `reg_addr` is 0x4 and `bank_sel` is 0. Writes at any other address or bank leave it unchanged. Reads anywhere else, including the write-only abort word at 0x0, return 0.
- R3: Bit 28 is a read/write power-up request and drives `pwr_req`. Bit 29 reads back the `pwr_ack` input. Bits 31:30 and 27:24 always read 0 and ignore writes.
- R4: A write at 0x0 with bit 0 set raises `abort_pulse` in the following cycle for exactly one cycle. In every other case `abort_pulse` stays low.
- R5: In the abort word, bit 3 clears the write-data error flag (word bit 7), bit 2 clears the sticky error flag (word bit 5) and bit 1 clears the sticky compare flag (word bit 4). A 0 in any of these bits has no effect.
- R6: The sticky error, sticky compare and write-data error flags set one cycle after their event input pulses, then hold until cleared. If an event and a clear arrive in the same cycle, the flag ends up set.
- R7: Writing the word with a 1 in bit 7, 5, 4 or 1 clears that flag. Writing 0 there leaves it unchanged.
- R8: The overrun flag (bit 1) sets on its event only while the overrun-detect enable (bit 0) is 1.
- R9: Bits 23:12 hold the transfer counter. A write loads it. It decrements by one for each `xfer_ok` pulse, stays at 0 without wrapping, and is unchanged when no successful transfer occurs, including on an abort. A load wins over a decrement in the same cycle.
- R10: Bit 6 takes the value of `rd_ok` in the cycle after each `rd_done` pulse and holds otherwise.
- R11: Bits 11:8 (lane mask), 3:2 (transfer mode) and 0 (overrun-detect enable) are read/write. They drive `lane_mask`, `xfer_mode` and `ovr_det_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_sel | input | BANK_W | Current register bank select value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| ev_stky_err | input | 1 | Sticky error event pulse |
| ev_stky_cmp | input | 1 | Sticky compare event pulse |
| ev_wdata_err | input | 1 | Write-data error event pulse |
| ev_overrun | input | 1 | Overrun event pulse |
| xfer_ok | input | 1 | Access-port transfer completed successfully |
| rd_done | input | 1 | Access-port read completed |
| rd_ok | input | 1 | Status of the completing read, 1 when error-free |
| abort_pulse | output | 1 | One-cycle abort of the current transfer |
| pwr_req | output | 1 | Debug clock power-up request |
| pwr_ack | input | 1 | Debug clock power-up acknowledge |
| seq_count | output | 12 | Remaining transfer count |
| lane_mask | output | 4 | Byte-lane mask |
| xfer_mode | output | 2 | Transfer mode |
| ovr_det_en | output | 1 | Overrun detection enable |

## Verification
The bench targets several corner cases:
- An event and a clear of the same flag in one cycle. A design that lets the clear win would drop an error and read the flag as 0.
- A counter at zero that still sees successful transfers. A wrapping design would read 0xFFF.
- A load and a decrement in the same cycle. Getting the priority wrong leaves the count off by one.
- A write made with a non-zero bank select, and an overrun event with detection disabled. Either one changing state shows up as a wrong word on the next read.
- Back-to-back abort words. These check that the strobe follows each write by exactly one cycle, with no stretching and no missed pulses.

// File: rtl/dbgp_pkg.sv
// Package: shared layout of the debug port control and status word.
// Assumes a 32-bit register port; bit positions are fixed by software.
package dbgp_pkg;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 12;
    localparam int LANE_W    = 4;
    localparam int MODE_W    = 2;
    localparam int N_FLAG    = 4;

    // byte offsets
    localparam int OFS_ABORT = 0;
    localparam int OFS_CSR   = 4;

    // control and status word bit positions
    localparam int B_ACK     = 29;
    localparam int B_REQ     = 28;
    localparam int B_CNT_LSB = 12;
    localparam int B_CNT_MSB = B_CNT_LSB + CNT_W - 1;
    localparam int B_LANE_LSB = 8;
    localparam int B_LANE_MSB = B_LANE_LSB + LANE_W - 1;
    localparam int B_WDERR   = 7;
    localparam int B_RDOK    = 6;
    localparam int B_SERR    = 5;
    localparam int B_SCMP    = 4;
    localparam int B_MODE_LSB = 2;
    localparam int B_MODE_MSB = B_MODE_LSB + MODE_W - 1;
    localparam int B_ORUN    = 1;
    localparam int B_OEN     = 0;

    // abort word bit positions
    localparam int A_WDERR_CLR = 3;
    localparam int A_SERR_CLR  = 2;
    localparam int A_SCMP_CLR  = 1;
    localparam int A_ABORT     = 0;

    // index of each sticky flag in the flag vector
    typedef enum int {
        FL_WDERR = 0,
        FL_SERR  = 1,
        FL_SCMP  = 2,
        FL_ORUN  = 3
    } flag_idx_e;

    // plain read/write control fields
    typedef struct packed {
        logic              req;
        logic [LANE_W-1:0] lane;
        logic [MODE_W-1:0] mode;
        logic              oen;
    } ctrl_t;
endpackage

// File: rtl/dbgp_decode.sv
// Module: address and bank decode for the two register words, plus the
// registered abort strobe. Assumes reg_addr is a byte offset and that the
// bank select value is held stable by the surrounding logic.
module dbgp_decode #(
    parameter int BANK_W = 4,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BANK_W-1:0]        bank_sel,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [dbgp_pkg::WORD_W-1:0] reg_wdata,
    output logic                     csr_sel,
    output logic                     csr_wr,
    output logic                     abt_wr,
    output logic                     abort_pulse
);
    import dbgp_pkg::*;

    localparam logic [ADDR_W-1:0] CSR_ADDR = ADDR_W'(OFS_CSR);
    localparam logic [ADDR_W-1:0] ABT_ADDR = ADDR_W'(OFS_ABORT);

    // Purpose: select the status word only in bank zero at its offset.
    always_comb begin
        csr_sel = (reg_addr == CSR_ADDR) && (bank_sel == '0);
        csr_wr  = reg_wr && csr_sel;
        abt_wr  = reg_wr && (reg_addr == ABT_ADDR);
    end

    // Purpose: emit a single-cycle abort strobe after an abort request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_pulse <= 1'b0;
        end else begin
            abort_pulse <= abt_wr && reg_wdata[A_ABORT];
        end
    end
endmodule

// File: rtl/dbgp_sticky.sv
// Module: a bank of sticky flags. Each flag sets on its event pulse and
// clears on its clear request; set has priority. Assumes event inputs are
// already qualified by any enables.
module dbgp_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Purpose: hold one flag; a coincident event wins over its clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_ev[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_req[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dbgp_xfer_count.sv
// Module: transfer counter for automatic incremental sequences. Loads on
// a register write, counts down per successful transfer and saturates at
// zero. Assumes at most one successful transfer per cycle.
module dbgp_xfer_count #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    logic at_zero;

    // Purpose: flag the floor so the counter never wraps.
    always_comb at_zero = (count == '0);

    // Purpose: load wins; otherwise step down unless already at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec && !at_zero) begin
            count <= count - ONE;
        end
    end
endmodule

// File: rtl/dbgp_csr.sv
// Module: debug port control and status register unit (top). Holds the
// control fields, sticky flags, read-status bit and transfer counter,
// and assembles the read word. Assumes event inputs are single-cycle
// pulses synchronous to clk.
module dbgp_csr #(
    parameter int BANK_W = 4,
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 ev_stky_err,
    input  logic                 ev_stky_cmp,
    input  logic                 ev_wdata_err,
    input  logic                 ev_overrun,
    input  logic                 xfer_ok,
    input  logic                 rd_done,
    input  logic                 rd_ok,
    output logic                 abort_pulse,
    output logic                 pwr_req,
    input  logic                 pwr_ack,
    output logic [11:0]          seq_count,
    output logic [3:0]           lane_mask,
    output logic [1:0]           xfer_mode,
    output logic                 ovr_det_en
);
    import dbgp_pkg::*;

    logic              csr_sel;
    logic              csr_wr;
    logic              abt_wr;
    ctrl_t             ctrl_q;
    logic              rdok_q;
    logic [N_FLAG-1:0] flag_set;
    logic [N_FLAG-1:0] flag_clr;
    logic [N_FLAG-1:0] flag_q;
    logic [CNT_W-1:0]  cnt_q;

    dbgp_decode #(
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W)
    ) i_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .bank_sel    (bank_sel),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .csr_sel     (csr_sel),
        .csr_wr      (csr_wr),
        .abt_wr      (abt_wr),
        .abort_pulse (abort_pulse)
    );

    // Purpose: qualify events and gather clears from both register words.
    always_comb begin
        flag_set[FL_WDERR] = ev_wdata_err;
        flag_set[FL_SERR]  = ev_stky_err;
        flag_set[FL_SCMP]  = ev_stky_cmp;
        flag_set[FL_ORUN]  = ev_overrun && ctrl_q.oen;

        flag_clr[FL_WDERR] = (csr_wr && reg_wdata[B_WDERR])
                           || (abt_wr && reg_wdata[A_WDERR_CLR]);
        flag_clr[FL_SERR]  = (csr_wr && reg_wdata[B_SERR])
                           || (abt_wr && reg_wdata[A_SERR_CLR]);
        flag_clr[FL_SCMP]  = (csr_wr && reg_wdata[B_SCMP])
                           || (abt_wr && reg_wdata[A_SCMP_CLR]);
        flag_clr[FL_ORUN]  = csr_wr && reg_wdata[B_ORUN];
    end

    dbgp_sticky #(
        .N (N_FLAG)
    ) i_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (flag_set),
        .clr_req (flag_clr),
        .flag_q  (flag_q)
    );

    dbgp_xfer_count #(
        .W (CNT_W)
    ) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (csr_wr),
        .load_val (reg_wdata[B_CNT_MSB:B_CNT_LSB]),
        .dec      (xfer_ok),
        .count    (cnt_q)
    );

    // Purpose: hold the plain read/write control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (csr_wr) begin
            ctrl_q.req  <= reg_wdata[B_REQ];
            ctrl_q.lane <= reg_wdata[B_LANE_MSB:B_LANE_LSB];
            ctrl_q.mode <= reg_wdata[B_MODE_MSB:B_MODE_LSB];
            ctrl_q.oen  <= reg_wdata[B_OEN];
        end
    end

    // Purpose: record the outcome of the latest access-port read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdok_q <= 1'b0;
        end else if (rd_done) begin
            rdok_q <= rd_ok;
        end
    end

    // Purpose: assemble the read word; reserved bits and other offsets read 0.
    always_comb begin
        reg_rdata = '0;
        if (csr_sel) begin
            reg_rdata[B_ACK]                  = pwr_ack;
            reg_rdata[B_REQ]                  = ctrl_q.req;
            reg_rdata[B_CNT_MSB:B_CNT_LSB]    = cnt_q;
            reg_rdata[B_LANE_MSB:B_LANE_LSB]  = ctrl_q.lane;
            reg_rdata[B_WDERR]                = flag_q[FL_WDERR];
            reg_rdata[B_RDOK]                 = rdok_q;
            reg_rdata[B_SERR]                 = flag_q[FL_SERR];
            reg_rdata[B_SCMP]                 = flag_q[FL_SCMP];
            reg_rdata[B_MODE_MSB:B_MODE_LSB]  = ctrl_q.mode;
            reg_rdata[B_ORUN]                 = flag_q[FL_ORUN];
            reg_rdata[B_OEN]                  = ctrl_q.oen;
        end
    end

    // Purpose: drive the control fields out to the access-port engine.
    always_comb begin
        pwr_req    = ctrl_q.req;
        lane_mask  = ctrl_q.lane;
        xfer_mode  = ctrl_q.mode;
        ovr_det_en = ctrl_q.oen;
        seq_count  = cnt_q;
    end
endmodule

// File: rtl/dbgp_csr_chk.sv
// Module: property checker for dbgp_csr, attached by bind. Observes the
// register port, event inputs, outputs and the sticky flag vector.
module dbgp_csr_chk #(
    parameter int BANK_W = 4,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BANK_W-1:0] bank_sel,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              ev_stky_err,
    input logic              xfer_ok,
    input logic              abort_pulse,
    input logic              pwr_ack,
    input logic [11:0]       seq_count,
    input logic [3:0]        flags
);
    logic sel_w, wr_w, abt_w;
    assign sel_w = (reg_addr == ADDR_W'(4)) && (bank_sel == '0);
    assign wr_w  = reg_wr && sel_w;
    assign abt_w = reg_wr && (reg_addr == ADDR_W'(0));

    // R4: abort request is followed by the strobe one cycle later
    a_r4_abort_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (abt_w && reg_wdata[0]) |=> abort_pulse);
    // R4: no request, no strobe
    a_r4_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(abt_w && reg_wdata[0]) |=> !abort_pulse);
    // R9: counter floor
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_count == 12'd0 && !wr_w) |=> (seq_count == 12'd0));
    // R9: single step down per successful transfer
    a_r9_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_count != 12'd0 && xfer_ok && !wr_w) |=> (seq_count == $past(seq_count) - 12'd1));
    // R9: no transfer, no change
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_ok && !wr_w) |=> $stable(seq_count));
    // R3: reserved bits read zero
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31:30] == 2'b00) && (reg_rdata[27:24] == 4'h0));
    // R3: acknowledge mirrored
    a_r3_ack_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        sel_w |-> (reg_rdata[29] == pwr_ack));
    // R2: other offsets and banks read zero
    a_r2_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_w |-> (reg_rdata == 32'h0));
    // R6: sticky error event sets its flag
    a_r6_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stky_err |=> flags[1]);
    // R6: sticky error holds without a clear
    a_r6_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !(wr_w && reg_wdata[5]) && !(abt_w && reg_wdata[2])) |=> flags[1]);
endmodule

bind dbgp_csr dbgp_csr_chk #(
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W)
) i_dbgp_csr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_sel    (bank_sel),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .ev_stky_err (ev_stky_err),
    .xfer_ok     (xfer_ok),
    .abort_pulse (abort_pulse),
    .pwr_ack     (pwr_ack),
    .seq_count   (seq_count),
    .flags       (flag_q)
);

// File: tb/test_dbgp_csr.sv
// Bench: directed corner cases then seeded random traffic, compared with
// a bench-side model built from the requirements.
module test_dbgp_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bank_sel = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_stky_err = 1'b0, ev_stky_cmp = 1'b0, ev_wdata_err = 1'b0, ev_overrun = 1'b0;
    logic        xfer_ok = 1'b0, rd_done = 1'b0, rd_ok = 1'b0;
    logic        abort_pulse, pwr_req;
    logic        pwr_ack = 1'b0;
    logic [11:0] seq_count;
    logic [3:0]  lane_mask;
    logic [1:0]  xfer_mode;
    logic        ovr_det_en;

    int n_cmp = 0;
    int n_bad = 0;

    // model state; m_flg: [0] wdata err, [1] sticky err, [2] sticky cmp, [3] overrun
    logic        m_req = 1'b0;
    logic [11:0] m_cnt = '0;
    logic [3:0]  m_mask = '0;
    logic [1:0]  m_mode = '0;
    logic        m_oen = 1'b0;
    logic [3:0]  m_flg = '0;
    logic        m_rdok = 1'b0;
    logic        m_abort = 1'b0;

    always #2 clk = ~clk;

    dbgp_csr #(.BANK_W(4), .ADDR_W(4)) i_dbgp_csr (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_stky_err(ev_stky_err), .ev_stky_cmp(ev_stky_cmp),
        .ev_wdata_err(ev_wdata_err), .ev_overrun(ev_overrun),
        .xfer_ok(xfer_ok), .rd_done(rd_done), .rd_ok(rd_ok),
        .abort_pulse(abort_pulse), .pwr_req(pwr_req), .pwr_ack(pwr_ack),
        .seq_count(seq_count), .lane_mask(lane_mask), .xfer_mode(xfer_mode),
        .ovr_det_en(ovr_det_en)
    );

    function automatic logic [31:0] exp_word(input logic ack);
        logic [31:0] w;
        w = '0;
        w[29] = ack;      w[28] = m_req;     w[23:12] = m_cnt;
        w[11:8] = m_mask; w[7] = m_flg[0];   w[6] = m_rdok;
        w[5] = m_flg[1];  w[4] = m_flg[2];   w[3:2] = m_mode;
        w[1] = m_flg[3];  w[0] = m_oen;
        return w;
    endfunction

    // read/write control fields only, flag bits zero so nothing is cleared
    function automatic logic [31:0] keep_fields();
        return {3'b000, m_req, 4'h0, m_cnt, m_mask, 4'h0, m_mode, 1'b0, m_oen};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One cycle: drive at posedge+1, check read at +2, update model at edge, check outputs.
    task automatic cyc(input logic wr, input logic [3:0] addr, input logic [3:0] bank,
                       input logic [31:0] wd, input logic [3:0] ev, input logic xok,
                       input logic rdd, input logic rok, input logic ack, input string tag);
        logic       csr_w, ab_w;
        logic [3:0] setv, clr;
        reg_wr = wr; reg_addr = addr; bank_sel = bank; reg_wdata = wd;
        ev_wdata_err = ev[0]; ev_stky_err = ev[1]; ev_stky_cmp = ev[2]; ev_overrun = ev[3];
        xfer_ok = xok; rd_done = rdd; rd_ok = rok; pwr_ack = ack;
        #1;
        check({tag, " R2/R3 read word"}, reg_rdata,
              (addr == 4'h4 && bank == 4'h0) ? exp_word(ack) : 32'h0);
        csr_w = wr && addr == 4'h4 && bank == 4'h0;
        ab_w  = wr && addr == 4'h0;
        setv  = {ev[3] & m_oen, ev[2], ev[1], ev[0]};
        clr   = {csr_w & wd[1],
                 (csr_w & wd[4]) | (ab_w & wd[1]),
                 (csr_w & wd[5]) | (ab_w & wd[2]),
                 (csr_w & wd[7]) | (ab_w & wd[3])};
        @(posedge clk);
        m_flg = setv | (m_flg & ~clr);
        if (csr_w) begin
            m_req = wd[28]; m_cnt = wd[23:12]; m_mask = wd[11:8];
            m_mode = wd[3:2]; m_oen = wd[0];
        end else if (xok && m_cnt != 12'd0) begin
            m_cnt = m_cnt - 12'd1;
        end
        if (rdd) m_rdok = rok;
        m_abort = ab_w & wd[0];
        #1;
        reg_wr = 1'b0; ev_wdata_err = 1'b0; ev_stky_err = 1'b0; ev_stky_cmp = 1'b0;
        ev_overrun = 1'b0; xfer_ok = 1'b0; rd_done = 1'b0;
        check({tag, " R4 abort strobe"}, {31'b0, abort_pulse}, {31'b0, m_abort});
        check({tag, " R9 count"}, {20'b0, seq_count}, {20'b0, m_cnt});
        check({tag, " R11/R3 outputs"}, {24'b0, pwr_req, lane_mask, xfer_mode, ovr_det_en},
              {24'b0, m_req, m_mask, m_mode, m_oen});
    endtask

    // Quiet read of the word at offset 0x04, bank 0.
    task automatic look(input string tag);
        cyc(1'b0, 4'h4, 4'h0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0, pwr_ack, tag);
    endtask

    initial begin : watchdog
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state, read while reset still held
        reg_addr = 4'h4; bank_sel = 4'h0;
        #1;
        check("R1 reset word", reg_rdata, 32'h0);
        check("R1 reset outputs", {27'b0, abort_pulse, pwr_req, seq_count == 12'd0, ovr_det_en, 1'b0},
              {27'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
        @(posedge clk); #1;
        rst_n = 1'b1;
        look("R1 after reset");

        // R11 / R3: program fields, reserved bits written high
        cyc(1'b1, 4'h4, 4'h0, 32'hCF00_0000 | (32'd1 << 28) | (32'd2 << 12) | (32'hA << 8) | (32'd2 << 2) | 32'd1,
            4'h0, 1'b0, 1'b0, 1'b0, 1'b1, "R11 program");
        look("R3 reserved read zero, ack high");

        // R9: count down to zero, then no wrap
        cyc(1'b0, 4'h4, 4'h0, 0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 dec 2->1");
        cyc(1'b0, 4'h4, 4'h0, 0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 dec 1->0");
        cyc(1'b0, 4'h4, 4'h0, 0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 floor");
        // R9: load beats decrement
        cyc(1'b1, 4'h4, 4'h0, keep_fields() | (32'd5 << 12), 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 load priority");

        // R2: write in another bank ignored
        cyc(1'b1, 4'h4, 4'h2, 32'h0FFF_FFFF, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 bank ignore");
        cyc(1'b1, 4'h8, 4'h0, 32'h0FFF_FFFF, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 offset ignore");
        look("R2 unchanged");

        // R6 / R8: all events, overrun enabled
        cyc(1'b0, 4'h4, 4'h0, 0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, "R6 set all");
        look("R6 R8 flags set");
        // R5: abort with zero clear bits does nothing
        cyc(1'b1, 4'h0, 4'h0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 zero no effect");
        cyc(1'b1, 4'h0, 4'h0, 32'h8, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 clear wdata err");
        cyc(1'b1, 4'h0, 4'h0, 32'h6, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 clear err and cmp");
        look("R5 after clears");
        // R7: write-1 clears overrun via status word
        cyc(1'b1, 4'h4, 4'h0, keep_fields() | 32'h2, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 w1c overrun");
        look("R7 after w1c");
        // R6: coincident set and clear keeps the flag
        cyc(1'b1, 4'h0, 4'h0, 32'h4, 4'h2, 1'b0, 1'b0, 1'b0, 1'b0, "R6 set wins");
        look("R6 flag kept");
        // R8: overrun disabled
        cyc(1'b1, 4'h4, 4'h0, keep_fields() & ~32'h1, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 disable");
        cyc(1'b0, 4'h4, 4'h0, 0, 4'h8, 1'b0, 1'b0, 1'b0, 1'b0, "R8 event masked");
        look("R8 overrun stays clear");
        // R4: back-to-back aborts, then quiet; count unchanged
        cyc(1'b1, 4'h0, 4'h0, 32'h1, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 abort a");
        cyc(1'b1, 4'h0, 4'h0, 32'h1, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 abort b");
        look("R4 strobe drops");
        // R10: read status
        cyc(1'b0, 4'h4, 4'h0, 0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, "R10 read ok");
        cyc(1'b0, 4'h4, 4'h0, 0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 hold");
        cyc(1'b0, 4'h4, 4'h0, 0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, "R10 read fail");
        look("R10 cleared");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic       wr;
            logic [3:0] addr, bank, ev;
            logic [31:0] wd;
            wr   = ($urandom % 6) == 0;
            addr = 4'(($urandom % 4) * 4);
            bank = (($urandom % 4) == 0) ? 4'($urandom % 4) : 4'h0;
            wd   = $urandom;
            if (($urandom % 3) != 0) wd[23:16] = 8'h0;
            ev   = 4'($urandom) & 4'($urandom);
            cyc(wr, addr, bank, wd, ev, ($urandom % 2) == 0, ($urandom % 4) == 0,
                1'($urandom), 1'($urandom), "RND");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule